// File: doc/BRIEF.md
# Eight-Channel Wavetable Playback Mixer

This block plays back up to eight streams of 8-bit samples held in an external 64 KB wave memory and mixes them into one stereo pair. A free-running tick timer divides the master clock into sample periods. At the start of each period, when the global enable is high, a sequencer walks the channels in order using a single synchronous read port. For every enabled channel it fetches one byte at the integer part of that channel's fixed-point position. It then advances the position, or jumps to the channel's loop point when the byte is the reserved loop marker.

Each fetched byte is decoded from sign-magnitude form and weighted by the channel's envelope. It is then scaled separately for the two sides by a 4-bit gain taken from the channel's pan byte. The weighted values are summed into wide accumulators, clamped to 16-bit signed, and published with a one-cycle valid pulse. All per-channel settings arrive as flat input vectors from a register file outside the block. The read port is meant to connect to a RAM that returns data one cycle after the request.

Top module: `pcm_mixer`

## Requirements
- R1: Channel c contributes only while bit c of `chan_on_i` is 1. While that bit is 0, the channel's position is held at its 8-bit start value shifted left by 19, so playback begins at byte address start*256 when the channel is enabled.
- R2: Each channel position is 27 bits (16 integer, 11 fraction). The RAM address driven for a fetch is position bits [26:11]. The byte on `ram_rd_data_i` is used in the cycle after `ram_rd_en_o` is high.
- R3: When the fetched byte is not 0xFF, the position is increased by the channel's 16-bit step, modulo 2^27.
- R4: When the fetched byte is 0xFF, the position becomes the 16-bit loop value shifted left by 11, without the step being added in that period. The byte at the loop address is fetched and used in place of the marker.
- R5: When the byte fetched at the loop address is also 0xFF, the channel adds nothing to either side in that period.
- R6: A sample byte with bit 7 set has the value +bits[6:0]. A byte with bit 7 clear has the value -bits[6:0].
- R7: Each enabled channel adds floor(value*envelope*g/32) to a side. For the left side, g is pan bits [3:0]; for the right side, g is pan bits [7:4]. The rounding is applied per channel, before the sum.
- R8: Each side's sum is clamped to -32768..32767 before it reaches `left_o` / `right_o`.
- R9: While `glb_en_i` is low, no RAM read is issued, both outputs read zero from the next cycle on, and the positions of enabled channels are left unchanged.
- R10: While the global enable stays high, `sample_valid_o` is a one-cycle pulse exactly every TICK_CYCLES (default 1536) cycles. The outputs change only together with that pulse.
- R11: After reset, both outputs are zero, `sample_valid_o` is low and every channel position is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en_i | input | 1 | Global run enable |
| chan_on_i | input | NUM_CH | Per-channel enable bits |
| env_i | input | NUM_CH*8 | Envelope per channel, channel c at [8c+7:8c] |
| pan_i | input | NUM_CH*8 | Pan per channel: [3:0] left gain, [7:4] right gain |
| step_i | input | NUM_CH*16 | Position increment per channel (5.11 fixed point) |
| loop_i | input | NUM_CH*16 | Loop byte address per channel |
| start_i | input | NUM_CH*8 | Start page per channel (byte address start*256) |
| ram_rd_en_o | output | 1 | Wave memory read request |
| ram_addr_o | output | 16 | Wave memory byte address |
| ram_rd_data_i | input | 8 | Wave memory data, valid one cycle after the request |
| left_o | output | 16 | Left mix, signed |
| right_o | output | 16 | Right mix, signed |
| sample_valid_o | output | 1 | One-cycle pulse when a new stereo pair is published |

## Verification
A corrupted channel position does not show until that channel's next fetch. It then appears as a wrong mix value at the next valid pulse, at most one sample period later, and keeps diverging afterwards because later fetches build on the bad position. Loop-marker mistakes show the same way: a missing jump, or a step applied in the jump period, changes the very next sample and every one after it. Errors in decoding or scaling, such as sign handling, floor rounding or the wrong pan nibble, appear in the pair published for the same period. A sequencer that drifts in timing, or keeps reading while disabled, shows as a valid pulse at the wrong distance from the previous one, or as read requests on the RAM port.

// File: rtl/pcm_mix_pkg.sv
// Package: widths, marker value, sequencer states and sample decoding shared by
// the wavetable mixer modules. Assumes 8-bit sign-magnitude samples.
package pcm_mix_pkg;
    localparam int SMP_W    = 8;
    localparam int ENV_W    = 8;
    localparam int PAN_W    = 8;
    localparam int NIB_W    = 4;
    localparam int STEP_W   = 16;
    localparam int LOOP_W   = 16;
    localparam int START_W  = 8;
    localparam int FRAC_W   = 11;
    localparam int INT_W    = 16;
    localparam int ADDR_W   = INT_W + FRAC_W;
    localparam int PROD_W   = SMP_W + ENV_W + NIB_W + 2;
    localparam int OUT_W    = 16;
    localparam int SCALE_SH = 5;

    localparam logic [SMP_W-1:0] LOOP_MARK = {SMP_W{1'b1}};

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_DATA,
        SQ_LOOP,
        SQ_DONE
    } seq_state_t;

    // Turn a sign-magnitude byte into a signed value (bit 7 set = positive).
    function automatic logic signed [PROD_W-1:0] smag_to_signed(input logic [SMP_W-1:0] b);
        logic signed [PROD_W-1:0] mag;
        mag = PROD_W'(b[SMP_W-2:0]);
        return b[SMP_W-1] ? mag : -mag;
    endfunction
endpackage

// File: rtl/pcm_tick_timer.sv
// Tick timer: free-running divider that raises tick_o for one cycle in every
// TICK_CYCLES master clocks. Assumes TICK_CYCLES >= 2.
module pcm_tick_timer #(
    parameter int TICK_CYCLES = 1536
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = $clog2(TICK_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count master clocks and wrap at the end of each sample period.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/pcm_chan_seq.sv
// Channel sequencer: on each tick (global enable high) visits every channel in
// a fixed three-cycle slot (issue, data, loop), drives the single RAM read port,
// keeps the 16.11 positions and reports usable sample bytes. Assumes the RAM
// returns data one cycle after a request and that channel settings are stable
// during a frame.
module pcm_chan_seq
    import pcm_mix_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_i,
    input  logic                      glb_en_i,
    input  logic [NUM_CH-1:0]         chan_on_i,
    input  logic [NUM_CH*STEP_W-1:0]  step_i,
    input  logic [NUM_CH*LOOP_W-1:0]  loop_i,
    input  logic [NUM_CH*START_W-1:0] start_i,
    output logic                      ram_rd_en_o,
    output logic [INT_W-1:0]          ram_addr_o,
    input  logic [SMP_W-1:0]          ram_rd_data_i,
    output logic                      frame_start_o,
    output logic                      contrib_valid_o,
    output logic [CH_W-1:0]           contrib_ch_o,
    output logic                      frame_done_o
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    logic [STEP_W-1:0]  step_a  [NUM_CH];
    logic [LOOP_W-1:0]  loop_a  [NUM_CH];
    logic [START_W-1:0] start_a [NUM_CH];
    logic [ADDR_W-1:0]  addr_q  [NUM_CH];

    seq_state_t       st_q, st_d;
    logic [CH_W-1:0]  ch_q, ch_d;
    logic             loop_q, loop_d;
    logic             addr_we, advance;
    logic [ADDR_W-1:0] addr_nxt;
    logic             is_mark;

    // Unpack the flat per-channel settings.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign step_a[g]  = step_i[g*STEP_W +: STEP_W];
        assign loop_a[g]  = loop_i[g*LOOP_W +: LOOP_W];
        assign start_a[g] = start_i[g*START_W +: START_W];
    end

    assign is_mark = (ram_rd_data_i == LOOP_MARK);

    // Next-state, read port and position update for the current slot.
    always_comb begin
        st_d            = st_q;
        ch_d            = ch_q;
        loop_d          = loop_q;
        ram_rd_en_o     = 1'b0;
        ram_addr_o      = addr_q[ch_q][ADDR_W-1:FRAC_W];
        addr_we         = 1'b0;
        addr_nxt        = addr_q[ch_q];
        contrib_valid_o = 1'b0;
        frame_start_o   = 1'b0;
        frame_done_o    = 1'b0;
        advance         = 1'b0;
        unique case (st_q)
            SQ_IDLE: begin
                if (tick_i && glb_en_i) begin
                    frame_start_o = 1'b1;
                    ch_d          = '0;
                    st_d          = SQ_ISSUE;
                end
            end
            SQ_ISSUE: begin
                loop_d = 1'b0;
                if (!glb_en_i) begin
                    st_d = SQ_IDLE;
                end else begin
                    ram_rd_en_o = chan_on_i[ch_q];
                    st_d        = SQ_DATA;
                end
            end
            SQ_DATA: begin
                if (!glb_en_i) begin
                    st_d = SQ_IDLE;
                end else begin
                    st_d = SQ_LOOP;
                    if (chan_on_i[ch_q]) begin
                        addr_we = 1'b1;
                        if (!is_mark) begin
                            contrib_valid_o = 1'b1;
                            addr_nxt        = addr_q[ch_q] + ADDR_W'(step_a[ch_q]);
                        end else begin
                            addr_nxt    = {loop_a[ch_q], FRAC_W'(0)};
                            ram_rd_en_o = 1'b1;
                            ram_addr_o  = loop_a[ch_q];
                            loop_d      = 1'b1;
                        end
                    end
                end
            end
            SQ_LOOP: begin
                if (!glb_en_i) begin
                    st_d = SQ_IDLE;
                end else begin
                    contrib_valid_o = loop_q && !is_mark;
                    advance         = 1'b1;
                end
            end
            SQ_DONE: begin
                frame_done_o = 1'b1;
                st_d         = SQ_IDLE;
            end
            default: st_d = SQ_IDLE;
        endcase
        if (advance) begin
            if (ch_q == LAST_CH) begin
                st_d = SQ_DONE;
            end else begin
                ch_d = ch_q + 1'b1;
                st_d = SQ_ISSUE;
            end
        end
    end

    // Sequencer state, channel index and loop-fetch flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            ch_q   <= '0;
            loop_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ch_q   <= ch_d;
            loop_q <= loop_d;
        end
    end

    // Channel positions: reload from start while disabled, else update in slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (!rst_n)
                addr_q[i] <= '0;
            else if (!chan_on_i[i])
                addr_q[i] <= {start_a[i], (ADDR_W-START_W)'(0)};
            else if (addr_we && ch_q == CH_W'(i))
                addr_q[i] <= addr_nxt;
        end
    end

    assign contrib_ch_o = ch_q;

    // R9: a low global enable stops the read port from the next cycle.
    assert_no_read_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |=> !ram_rd_en_o);

    // R2: a sample byte is only consumed one cycle after a read request.
    assert_data_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        contrib_valid_o |-> $past(ram_rd_en_o));
endmodule

// File: rtl/pcm_voice_scale.sv
// Voice scaler: decodes one sign-magnitude sample and forms
// floor(value * envelope * gain / 32) for one output side. Purely combinational.
module pcm_voice_scale
    import pcm_mix_pkg::*;
(
    input  logic [SMP_W-1:0]         smp_i,
    input  logic [ENV_W-1:0]         env_i,
    input  logic [NIB_W-1:0]         gain_i,
    output logic signed [PROD_W-1:0] contrib_o
);
    logic signed [PROD_W-1:0] value, env_s, gain_s, prod;

    // Signed three-way product followed by an arithmetic scale-down.
    always_comb begin
        value     = smag_to_signed(smp_i);
        env_s     = PROD_W'(env_i);
        gain_s    = PROD_W'(gain_i);
        prod      = value * env_s * gain_s;
        contrib_o = prod >>> SCALE_SH;
    end
endmodule

// File: rtl/pcm_mix_accum.sv
// Mix accumulator: sums per-channel contributions for both sides over a frame,
// clamps to 16-bit signed and publishes with a one-cycle valid. Forces zero
// outputs while the global enable is low and still pulses valid on each tick.
module pcm_mix_accum
    import pcm_mix_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int ACC_W = PROD_W + ((NUM_CH > 1) ? $clog2(NUM_CH) : 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     glb_en_i,
    input  logic                     tick_i,
    input  logic                     frame_start_i,
    input  logic                     contrib_valid_i,
    input  logic signed [PROD_W-1:0] left_c_i,
    input  logic signed [PROD_W-1:0] right_c_i,
    input  logic                     frame_done_i,
    output logic signed [OUT_W-1:0]  left_o,
    output logic signed [OUT_W-1:0]  right_o,
    output logic                     valid_o
);
    localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'({1'b0, {(OUT_W-1){1'b1}}});
    localparam logic signed [ACC_W-1:0] NEG_LIM = ~POS_LIM;

    logic signed [ACC_W-1:0] acc_l_q, acc_r_q;

    // Clamp a wide sum into the signed output range.
    function automatic logic signed [OUT_W-1:0] clamp(input logic signed [ACC_W-1:0] a);
        if (a > POS_LIM)      return {1'b0, {(OUT_W-1){1'b1}}};
        else if (a < NEG_LIM) return {1'b1, {(OUT_W-1){1'b0}}};
        else                  return a[OUT_W-1:0];
    endfunction

    // Accumulate contributions, cleared at the start of every frame.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start_i) begin
            acc_l_q <= '0;
            acc_r_q <= '0;
        end else if (contrib_valid_i) begin
            acc_l_q <= acc_l_q + ACC_W'(left_c_i);
            acc_r_q <= acc_r_q + ACC_W'(right_c_i);
        end
    end

    // Publish the clamped pair, or zeros while globally disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_o  <= '0;
            right_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (!glb_en_i) begin
                left_o  <= '0;
                right_o <= '0;
                valid_o <= tick_i;
            end else if (frame_done_i) begin
                left_o  <= clamp(acc_l_q);
                right_o <= clamp(acc_r_q);
                valid_o <= 1'b1;
            end
        end
    end

    // R9: outputs read zero one cycle after the global enable is seen low.
    assert_zero_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |=> (left_o == '0 && right_o == '0));

    // R10: the valid strobe never lasts more than one cycle.
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R10: while enabled, outputs only move together with the valid strobe.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && $past(glb_en_i)) |-> ($stable(left_o) && $stable(right_o)));
endmodule

// File: rtl/pcm_mixer.sv
// Top: eight-channel wavetable playback mixer. Ties the tick timer, channel
// sequencer, per-side voice scalers and mix accumulator together. Assumes a
// synchronous RAM with one-cycle read latency on the ram_* port and
// TICK_CYCLES >= 3*NUM_CH + 3.
module pcm_mixer
    import pcm_mix_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int TICK_CYCLES = 1536
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      glb_en_i,
    input  logic [NUM_CH-1:0]         chan_on_i,
    input  logic [NUM_CH*ENV_W-1:0]   env_i,
    input  logic [NUM_CH*PAN_W-1:0]   pan_i,
    input  logic [NUM_CH*STEP_W-1:0]  step_i,
    input  logic [NUM_CH*LOOP_W-1:0]  loop_i,
    input  logic [NUM_CH*START_W-1:0] start_i,
    output logic                      ram_rd_en_o,
    output logic [INT_W-1:0]          ram_addr_o,
    input  logic [SMP_W-1:0]          ram_rd_data_i,
    output logic signed [OUT_W-1:0]   left_o,
    output logic signed [OUT_W-1:0]   right_o,
    output logic                      sample_valid_o
);
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SIDES = 2;

    logic                     tick;
    logic                     frame_start, frame_done, contrib_valid;
    logic [CH_W-1:0]          contrib_ch;
    logic [ENV_W-1:0]         env_a [NUM_CH];
    logic [PAN_W-1:0]         pan_a [NUM_CH];
    logic [PAN_W-1:0]         pan_sel;
    logic signed [PROD_W-1:0] side_c [SIDES];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign env_a[g] = env_i[g*ENV_W +: ENV_W];
        assign pan_a[g] = pan_i[g*PAN_W +: PAN_W];
    end

    assign pan_sel = pan_a[contrib_ch];

    pcm_tick_timer #(.TICK_CYCLES(TICK_CYCLES)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    pcm_chan_seq #(.NUM_CH(NUM_CH)) i_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_i          (tick),
        .glb_en_i        (glb_en_i),
        .chan_on_i       (chan_on_i),
        .step_i          (step_i),
        .loop_i          (loop_i),
        .start_i         (start_i),
        .ram_rd_en_o     (ram_rd_en_o),
        .ram_addr_o      (ram_addr_o),
        .ram_rd_data_i   (ram_rd_data_i),
        .frame_start_o   (frame_start),
        .contrib_valid_o (contrib_valid),
        .contrib_ch_o    (contrib_ch),
        .frame_done_o    (frame_done)
    );

    // One scaler per output side: side 0 uses pan[3:0], side 1 uses pan[7:4].
    for (genvar s = 0; s < SIDES; s++) begin : g_side
        pcm_voice_scale i_scale (
            .smp_i     (ram_rd_data_i),
            .env_i     (env_a[contrib_ch]),
            .gain_i    (pan_sel[s*NIB_W +: NIB_W]),
            .contrib_o (side_c[s])
        );
    end

    pcm_mix_accum #(.NUM_CH(NUM_CH)) i_accum (
        .clk             (clk),
        .rst_n           (rst_n),
        .glb_en_i        (glb_en_i),
        .tick_i          (tick),
        .frame_start_i   (frame_start),
        .contrib_valid_i (contrib_valid),
        .left_c_i        (side_c[0]),
        .right_c_i       (side_c[1]),
        .frame_done_i    (frame_done),
        .left_o          (left_o),
        .right_o         (right_o),
        .valid_o         (sample_valid_o)
    );
endmodule

// File: tb/test_pcm_mixer.sv
// Bench: directed corner cases plus seeded random frames, each checked against
// a behavioural model of the requirements. Provides a 256-byte RAM model that
// folds the 16-bit address as addr[7:0]^addr[15:8].
module test_pcm_mixer;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int TICK       = 1536;
    localparam int WD_CYCLES  = 190000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic               rst_n, glb_en;
    logic [NCH-1:0]     chan_on;
    logic [NCH*8-1:0]   env, pan, start;
    logic [NCH*16-1:0]  step, loopv;
    logic               ram_rd_en;
    logic [15:0]        ram_addr;
    logic [7:0]         ram_q;
    logic signed [15:0] left, right;
    logic               sample_valid;

    logic [7:0]  mem [256];
    logic [26:0] maddr [NCH];

    int checks = 0, failures = 0, cyc = 0, off_reads = 0, last_cyc = -1;
    bit last_glb = 1'b0, done = 1'b0;

    pcm_mixer i_pcm_mixer (
        .clk            (clk),
        .rst_n          (rst_n),
        .glb_en_i       (glb_en),
        .chan_on_i      (chan_on),
        .env_i          (env),
        .pan_i          (pan),
        .step_i         (step),
        .loop_i         (loopv),
        .start_i        (start),
        .ram_rd_en_o    (ram_rd_en),
        .ram_addr_o     (ram_addr),
        .ram_rd_data_i  (ram_q),
        .left_o         (left),
        .right_o        (right),
        .sample_valid_o (sample_valid)
    );

    function automatic logic [7:0] ridx(input logic [15:0] a);
        return a[7:0] ^ a[15:8];
    endfunction

    // RAM model with one-cycle latency; also counts reads while disabled.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ram_rd_en) ram_q <= mem[ridx(ram_addr)];
        if (ram_rd_en && !glb_en) off_reads <= off_reads + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected stereo pair for one period, advancing the model positions.
    task automatic model(output int el, output int er);
        el = 0;
        er = 0;
        for (int c = 0; c < NCH; c++) begin
            logic [7:0] b;
            int v, e, pl, pr;
            if (!chan_on[c]) begin
                maddr[c] = {start[c*8 +: 8], 19'd0};
                continue;
            end
            if (!glb_en) continue;
            b = mem[ridx(maddr[c][26:11])];
            if (b != 8'hFF) begin
                maddr[c] = maddr[c] + {11'd0, step[c*16 +: 16]};
            end else begin
                maddr[c] = {loopv[c*16 +: 16], 11'd0};
                b = mem[ridx(loopv[c*16 +: 16])];
            end
            if (b != 8'hFF) begin
                v  = b[7] ? int'(b[6:0]) : -int'(b[6:0]);
                e  = int'(env[c*8 +: 8]);
                pl = int'(pan[c*8 +: 4]);
                pr = int'(pan[c*8+4 +: 4]);
                el += (v * e * pl) >>> 5;
                er += (v * e * pr) >>> 5;
            end
        end
        if (el > 32767) el = 32767;
        if (el < -32768) el = -32768;
        if (er > 32767) er = 32767;
        if (er < -32768) er = -32768;
    endtask

    task automatic run_sample(input string tag, output int al, output int ar);
        int el, er;
        model(el, er);
        do @(negedge clk); while (!sample_valid);
        al = int'(left);
        ar = int'(right);
        chk({tag, " left"}, al, el);
        chk({tag, " right"}, ar, er);
        if (glb_en && last_glb && last_cyc >= 0)
            chk("R10 period", cyc - last_cyc, TICK);
        last_cyc = cyc;
        last_glb = glb_en;
        @(negedge clk);
        chk("R10 pulse width", int'(sample_valid), 0);
    endtask

    task automatic fill_mem(input logic [7:0] val);
        for (int i = 0; i < 256; i++) mem[i] = val;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog: actual=no_finish expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int al, ar;
        void'($urandom(32'd90210));
        rst_n = 1'b0; glb_en = 1'b0; chan_on = '0;
        env = '0; pan = '0; start = '0; step = '0; loopv = '0;
        ram_q = '0;
        fill_mem(8'h80);
        for (int c = 0; c < NCH; c++) maddr[c] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 reset left", int'(left), 0);
        chk("R11 reset right", int'(right), 0);
        chk("R11 reset valid", int'(sample_valid), 0);

        // R6/R7: positive byte, distinct pan nibbles per side
        glb_en = 1'b1;
        fill_mem(8'h83);
        chan_on = 8'h01; env[7:0] = 8'd32; pan[7:0] = 8'h21; step[15:0] = 16'h0800;
        run_sample("R6 R7 positive", al, ar);
        chk("R7 literal left", al, 3);
        chk("R7 literal right", ar, 6);
        // R6: bit 7 clear means negative
        fill_mem(8'h03);
        run_sample("R6 negative", al, ar);
        chk("R6 literal left", al, -3);
        chk("R6 literal right", ar, -6);
        // R7: per-channel floor of a small negative product
        fill_mem(8'h01); env[7:0] = 8'd1; pan[7:0] = 8'h11;
        run_sample("R7 floor", al, ar);
        chk("R7 floor literal", al, -1);

        // R1: only the enabled channel counts
        chan_on = 8'h00;
        run_sample("R1 all off", al, ar);
        env = '1; pan = '1; fill_mem(8'h83);
        env[31:24] = 8'd32; pan[31:24] = 8'h11;
        chan_on = 8'h08;
        run_sample("R1 one channel", al, ar);
        chk("R1 literal", al, 3);

        // R4/R3: loop marker jump, no step that period, then stepping resumes
        chan_on = 8'h00; env = '0; pan = '0; start = '0;
        run_sample("R1 reload", al, ar);
        fill_mem(8'h90); mem[0] = 8'hFF; mem[5] = 8'hC0;
        chan_on = 8'h01; env[7:0] = 8'd32; pan[7:0] = 8'h11;
        step[15:0] = 16'h0800; loopv[15:0] = 16'h0005;
        run_sample("R4 jump", al, ar);
        chk("R4 literal jump", al, 64);
        run_sample("R4 no step on jump", al, ar);
        chk("R4 literal after jump", al, 64);
        run_sample("R3 step", al, ar);
        chk("R3 literal step", al, 16);

        // R5: marker at the loop address too
        chan_on = 8'h00;
        run_sample("R1 reload again", al, ar);
        mem[5] = 8'hFF; chan_on = 8'h01;
        run_sample("R5 double marker", al, ar);
        chk("R5 literal", al, 0);
        chk("R5 literal right", ar, 0);

        // R8: clamp both ways
        chan_on = 8'hFF; env = '1; pan = '1; step = '0;
        fill_mem(8'hFE);
        run_sample("R8 positive clamp", al, ar);
        chk("R8 literal max", al, 32767);
        fill_mem(8'h7E);
        run_sample("R8 negative clamp", al, ar);
        chk("R8 literal min", ar, -32768);

        // R9: global disable, then resume from frozen positions
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        for (int c = 0; c < NCH; c++) step[c*16 +: 16] = 16'($urandom % 16'h3000);
        glb_en = 1'b0;
        repeat (3) run_sample("R9 disabled", al, ar);
        chk("R9 no reads while off", off_reads, 0);
        glb_en = 1'b1;
        run_sample("R9 resume", al, ar);

        // R2/R3/R7: seeded random frames
        repeat (40) begin
            for (int i = 0; i < 256; i++)
                mem[i] = (($urandom % 8) == 0) ? 8'hFF : 8'($urandom);
            chan_on = 8'($urandom);
            env     = {$urandom, $urandom};
            pan     = {$urandom, $urandom};
            start   = {$urandom, $urandom};
            loopv   = {$urandom, $urandom, $urandom, $urandom};
            for (int c = 0; c < NCH; c++) step[c*16 +: 16] = 16'($urandom % 16'h4000);
            glb_en  = (($urandom % 10) != 0);
            run_sample("R2 R3 R7 random", al, ar);
        end
        chk("R9 no reads while off total", off_reads, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule